// File: doc/BRIEF.md
# Shape-Selectable Single-Port Synchronous RAM

This block is a single-port RAM with a registered read output. Its storage is always the same: a 16384-bit data array and a 2048-bit parity array. An elaboration parameter chooses the word shape the port presents:

| Words | Bits per word |
|-------|---------------|
| 16384 | 1 |
| 8192 | 2 |
| 4096 | 4 |
| 2048 | 9 |
| 1024 | 18 |

In the two widest shapes the extra bits of each word are kept in the parity array. They share the word's address.

A second parameter sets what the output register shows in a cycle that writes. It can show the word that was there before the write, the word being written, or it can keep its previous value.

Clients drive an enable, a write strobe, an address and write data. A read result appears on the output one rising edge after the read cycle. A synchronous reset clears only the output register.

Top module: `blkram_cfg`

## Requirements
- R1: The port width is one of 1, 2, 4, 9 or 18. The address width is 14, 13, 12, 11 or 10 for those widths. A word written at any address, including the highest, is returned by a later read of that address.
- R2: For the 9-bit shape, bits [7:0] are data and bit 8 is parity. For the 18-bit shape, bits [15:0] are data and bits [17:16] are parity. Parity bits are stored and returned with their word, and they are independent of other addresses.
- R3: A cycle with enable high and write low loads the addressed word into the output register at that rising edge. Between edges the output does not change.
- R4: A cycle with enable low performs no write, and the output register keeps its value. This holds even when the write strobe is high.
- R5: With the old-data write policy, a write cycle loads the word previously stored at the address into the output, then stores the new word. Back-to-back writes to one address each return the word written just before.
- R6: With the new-data write policy, a write cycle stores the input word and loads that same word into the output.
- R7: With the hold write policy, a write cycle stores the input word and leaves the output unchanged.
- R8: Synchronous reset takes priority over any output update and clears the output to zero at the next rising edge. It does not alter stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset of the output register |
| en | input | 1 | Port enable; gates both reads and writes |
| we | input | 1 | Write strobe, valid when en is high |
| addr | input | AW | Word address, width set by the shape |
| din | input | PORT_W | Write word (parity in the top bits for 9/18) |
| dout | output | PORT_W | Registered read word |

## Verification
The assertions check on every cycle the output register's behaviour:

- It holds when the port is disabled.
- It is cleared after reset.
- It takes the addressed word on reads.
- On writes it follows the selected write policy.
- A written word lands at the bit slice its address selects.

Only the bench's scenarios can show that whole-array contents survive across every shape. The same applies to the independence of aliasing addresses, to parity bits surviving with their word, and to stored data surviving a reset. These are checked against a behavioural word model.

// File: rtl/blkram_pkg.sv
package blkram_pkg;
   localparam int DATA_BITS = 16384;
   localparam int PAR_BITS  = 2048;

   typedef enum logic [1:0] {
      WM_OLD  = 2'd0,
      WM_NEW  = 2'd1,
      WM_HOLD = 2'd2
   } wmode_e;

   function automatic int data_w(input int w);
      return (w == 9) ? 8 : (w == 18) ? 16 : w;
   endfunction

   function automatic int par_w(input int w);
      return (w == 9) ? 1 : (w == 18) ? 2 : 0;
   endfunction

   function automatic bit shape_ok(input int w);
      return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18);
   endfunction
endpackage

// File: rtl/blkram_array.sv
module blkram_array
   import blkram_pkg::*;
#(
   parameter int DW  = 16,
   parameter int PW  = 2,
   parameter int AW  = 10,
   localparam int PWX = (PW > 0) ? PW : 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           wr_en,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata_d,
   input  logic [PWX-1:0] wdata_p,
   output logic [DW-1:0]  rdata_d,
   output logic [PWX-1:0] rdata_p
);
   localparam int IW = $clog2(DATA_BITS);
   localparam int SH = $clog2(DW);

   logic [DATA_BITS-1:0] data_bits;
   logic [IW-1:0]        dbase;

   assign dbase   = IW'(addr) << SH;
   assign rdata_d = data_bits[dbase +: DW];

   always_ff @(posedge clk) begin
      if (wr_en) data_bits[dbase +: DW] <= wdata_d;
   end

   generate
      if ((DW << AW) != DATA_BITS) begin : g_bad_data_fit
         $error("data slice does not tile the data array");
      end

      if (PW > 0) begin : g_par
         localparam int PIW = $clog2(PAR_BITS);
         localparam int PSH = $clog2(PW);
         logic [PAR_BITS-1:0] par_bits;
         logic [PIW-1:0]      pbase;

         if ((PW << AW) != PAR_BITS) begin : g_bad_par_fit
            $error("parity slice does not tile the parity array");
         end

         assign pbase   = PIW'(addr) << PSH;
         assign rdata_p = par_bits[pbase +: PW];

         always_ff @(posedge clk) begin
            if (wr_en) par_bits[pbase +: PW] <= wdata_p;
         end

         assert_par_lands_R2: assert property (@(posedge clk) disable iff (rst)
            wr_en |=> ($stable(addr) -> (rdata_p == $past(wdata_p))));
      end else begin : g_nopar
         logic unused_par;
         assign unused_par = ^wdata_p;
         assign rdata_p    = '0;
      end
   endgenerate

   assert_write_lands_R1: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> ($stable(addr) -> (rdata_d == $past(wdata_d))));
endmodule

// File: rtl/blkram_outreg.sv
module blkram_outreg
   import blkram_pkg::*;
#(
   parameter int     W    = 18,
   parameter wmode_e MODE = WM_OLD
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         we,
   input  logic [W-1:0] rd_word,
   input  logic [W-1:0] wr_word,
   output logic [W-1:0] dout
);
   generate
      if (MODE == WM_OLD) begin : g_old
         logic unused_wr;
         assign unused_wr = ^wr_word;
         always_ff @(posedge clk) begin
            if (rst)     dout <= '0;
            else if (en) dout <= rd_word;
         end
         assert_old_on_write_R5: assert property (@(posedge clk) disable iff (rst)
            (en && we) |=> (dout == $past(rd_word)));
      end else if (MODE == WM_NEW) begin : g_new
         always_ff @(posedge clk) begin
            if (rst)     dout <= '0;
            else if (en) dout <= we ? wr_word : rd_word;
         end
         assert_new_on_write_R6: assert property (@(posedge clk) disable iff (rst)
            (en && we) |=> (dout == $past(wr_word)));
      end else begin : g_hold
         logic unused_wr;
         assign unused_wr = ^wr_word;
         always_ff @(posedge clk) begin
            if (rst)             dout <= '0;
            else if (en && !we)  dout <= rd_word;
         end
         assert_hold_on_write_R7: assert property (@(posedge clk) disable iff (rst)
            (en && we) |=> $stable(dout));
      end
   endgenerate

   assert_idle_keeps_R4: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(dout));

   assert_read_loads_R3: assert property (@(posedge clk) disable iff (rst)
      (en && !we) |=> (dout == $past(rd_word)));

   assert_reset_clears_R8: assert property (@(posedge clk)
      rst |=> (dout == '0));
endmodule

// File: rtl/blkram_cfg.sv
module blkram_cfg
   import blkram_pkg::*;
#(
   parameter int     PORT_W = 18,
   parameter wmode_e MODE   = WM_OLD,
   localparam int DW  = data_w(PORT_W),
   localparam int PW  = par_w(PORT_W),
   localparam int PWX = (PW > 0) ? PW : 1,
   localparam int AW  = $clog2(DATA_BITS / DW)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [PORT_W-1:0] din,
   output logic [PORT_W-1:0] dout
);
   logic [DW-1:0]     wd_d, rd_d;
   logic [PWX-1:0]    wd_p, rd_p;
   logic [PORT_W-1:0] rd_word;

   generate
      if (!shape_ok(PORT_W)) begin : g_bad_shape
         $error("PORT_W must be 1, 2, 4, 9 or 18");
      end

      if (PW > 0) begin : g_split
         assign wd_d    = din[DW-1:0];
         assign wd_p    = din[PORT_W-1:DW];
         assign rd_word = {rd_p, rd_d};
      end else begin : g_flat
         logic unused_rp;
         assign unused_rp = ^rd_p;
         assign wd_d    = din;
         assign wd_p    = '0;
         assign rd_word = rd_d;
      end
   endgenerate

   blkram_array #(.DW(DW), .PW(PW), .AW(AW)) u_array (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (en && we),
      .addr    (addr),
      .wdata_d (wd_d),
      .wdata_p (wd_p),
      .rdata_d (rd_d),
      .rdata_p (rd_p)
   );

   blkram_outreg #(.W(PORT_W), .MODE(MODE)) u_outreg (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .we      (we),
      .rd_word (rd_word),
      .wr_word (din),
      .dout    (dout)
   );
endmodule

// File: tb/tb_blkram_cfg.sv
module tb_blkram_cfg;
   import blkram_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NI = 6;
   localparam int WIDTHS [NI] = '{1, 2, 4, 9, 18, 18};
   localparam wmode_e MODES [NI] = '{WM_OLD, WM_NEW, WM_HOLD, WM_OLD, WM_NEW, WM_HOLD};

   typedef struct packed {
      logic        en;
      logic        we;
      logic [13:0] a;
      logic [17:0] d;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b1, 14'd100,   18'h3A5C1},
      '{1'b1, 1'b1, 14'd100,   18'h05A3E},
      '{1'b1, 1'b0, 14'd100,   18'h00000},
      '{1'b0, 1'b1, 14'd100,   18'h3FFFF},
      '{1'b1, 1'b0, 14'd100,   18'h00000},
      '{1'b1, 1'b1, 14'd0,     18'h2AAAA},
      '{1'b1, 1'b0, 14'd0,     18'h00000},
      '{1'b0, 1'b0, 14'd7,     18'h00000},
      '{1'b1, 1'b1, 14'd16383, 18'h15555},
      '{1'b1, 1'b0, 14'd16383, 18'h00000},
      '{1'b1, 1'b1, 14'd1023,  18'h0ABCD},
      '{1'b1, 1'b0, 14'd1023,  18'h00000},
      '{1'b1, 1'b1, 14'd1023,  18'h3F00F},
      '{1'b1, 1'b1, 14'd1023,  18'h00FF0},
      '{1'b1, 1'b0, 14'd1023,  18'h00000},
      '{1'b1, 1'b0, 14'd100,   18'h00000}
   };

   function automatic int depth_of(input int w);
      return 16384 / data_w(w);
   endfunction

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        en  = 1'b0;
   logic        we  = 1'b0;
   logic [13:0] a_bus = '0;
   logic [17:0] d_bus = '0;
   logic [17:0] obs [NI];
   logic [17:0] expv [NI];
   logic [17:0] refm [NI][16384];
   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   for (genvar g = 0; g < NI; g++) begin : g_inst
      localparam int W  = WIDTHS[g];
      localparam int AW = $clog2(depth_of(W));
      logic [W-1:0] q;
      blkram_cfg #(.PORT_W(W), .MODE(MODES[g])) dut (
         .clk (clk), .rst (rst), .en (en), .we (we),
         .addr (a_bus[AW-1:0]), .din (d_bus[W-1:0]), .dout (q)
      );
      assign obs[g] = 18'(q);
   end

   function automatic logic [17:0] wmask(input int g);
      return 18'((19'd1 << WIDTHS[g]) - 19'd1);
   endfunction

   function automatic string policy_tag(input int g);
      case (MODES[g])
         WM_OLD:  return "R5";
         WM_NEW:  return "R6";
         default: return "R7";
      endcase
   endfunction

   // One clock cycle: drive at negedge, model at posedge, compare at next negedge.
   task automatic step(input logic r, input logic e, input logic w,
                       input logic [13:0] adr, input logic [17:0] dat,
                       input string tag, input bit check);
      rst = r; en = e; we = w; a_bus = adr; d_bus = dat;
      @(posedge clk);
      for (int g = 0; g < NI; g++) begin
         int ix = int'(adr) & (depth_of(WIDTHS[g]) - 1);
         logic [17:0] old = refm[g][ix];
         logic [17:0] nd  = dat & wmask(g);
         if (e && w) refm[g][ix] = nd;
         if (r) expv[g] = '0;
         else if (e && !w) expv[g] = old;
         else if (e && w) begin
            if (MODES[g] == WM_OLD) expv[g] = old;
            else if (MODES[g] == WM_NEW) expv[g] = nd;
         end
      end
      @(negedge clk);
      if (check) begin
         for (int g = 0; g < NI; g++) begin
            string t;
            if (tag != "") t = tag;
            else if (r) t = "R8";
            else if (!e) t = "R4";
            else if (w) t = policy_tag(g);
            else t = "R3";
            total++;
            if ((obs[g] & wmask(g)) !== expv[g]) begin
               bad++;
               $display("FAIL %s inst=%0d w=%0d addr=%0d actual=%h expected=%h",
                        t, g, WIDTHS[g], adr, obs[g] & wmask(g), expv[g]);
            end
         end
      end
   endtask

   initial begin
      for (int g = 0; g < NI; g++) expv[g] = '0;
      @(negedge clk);
      // R8: reset value of the output register
      step(1'b1, 1'b0, 1'b0, 14'd0, 18'd0, "R8", 1'b1);
      step(1'b1, 1'b0, 1'b0, 14'd0, 18'd0, "R8", 1'b1);
      // fill every word with zero so old-data reads are defined
      for (int i = 0; i < 16384; i++)
         step(1'b0, 1'b1, 1'b1, 14'(i), 18'd0, "", 1'b0);
      for (int g = 0; g < NI; g++) expv[g] = '0;
      step(1'b1, 1'b0, 1'b0, 14'd0, 18'd0, "R8", 1'b1);
      // R1: pattern written to every address, then read back across all shapes
      for (int i = 0; i < 16384; i++)
         step(1'b0, 1'b1, 1'b1, 14'(i), 18'((i * 'h2D3 + 'h1F) ^ (i << 5)), "", 1'b1);
      for (int i = 0; i < 16384; i++)
         step(1'b0, 1'b1, 1'b0, 14'(i), 18'd0, "R1", 1'b1);
      // table-driven scenarios: R3..R7
      for (int v = 0; v < NV; v++)
         step(1'b0, VECS[v].en, VECS[v].we, VECS[v].a, VECS[v].d, "", 1'b1);
      // R2: parity-only bits and data-only bits at neighbouring addresses
      step(1'b0, 1'b1, 1'b1, 14'd5, 18'h30100, "", 1'b1);
      step(1'b0, 1'b1, 1'b1, 14'd6, 18'h000FF, "", 1'b1);
      step(1'b0, 1'b1, 1'b0, 14'd5, 18'd0, "R2", 1'b1);
      step(1'b0, 1'b1, 1'b0, 14'd6, 18'd0, "R2", 1'b1);
      // R8: reset mid-run clears output, stored words survive
      step(1'b0, 1'b1, 1'b0, 14'd16383, 18'd0, "R3", 1'b1);
      step(1'b1, 1'b1, 1'b0, 14'd16383, 18'd0, "R8", 1'b1);
      step(1'b0, 1'b0, 1'b0, 14'd0, 18'd0, "R4", 1'b1);
      step(1'b0, 1'b1, 1'b0, 14'd16383, 18'd0, "R8", 1'b1);
      step(1'b0, 1'b1, 1'b0, 14'd100, 18'd0, "R8", 1'b1);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule